// File: doc/BRIEF.md
# Sixteen-bit execute-stage arithmetic and result selector

This block is the execute stage of a small pipelined RISC core. In every cycle it evaluates all of its functional units in parallel from the same operands. These units are an adder/subtractor, a two-input logic unit, a one-place left shifter and a one-place right shifter. It also has two pass-through sources: a zero-extended byte from the load path and a return address for link instructions. A decoded operation class picks at most one of these sources. That source reaches the 16-bit result through an AND-OR selector driven by one-hot, active-low unit enables. When no source is enabled the result is zero.

Carry-chained add and subtract forms take their carry-in from a one-bit carry flag held inside the block. The flag takes the adder's carry-out only at the end of an arithmetic-class operation and keeps its value through every other operation. A chained operation therefore sees the carry of the most recent arithmetic step, even when unrelated instructions come in between.

Top module: `ex_alu16`

## Requirements
- R1: For class ADD (1) the result is op_a + op_b with carry-in 0. For class ADC (3) the carry-in is the carry flag. carry_out is bit 16 of the 17-bit sum.
- R2: For class SUB (2) the result is op_a + ~op_b + 1. For class SBC (4) it is op_a + ~op_b + (1 XOR carry flag). carry_out is bit 16 of that 17-bit sum.
- R3: For class LOGIC (5), fn_sel chooses the operation: 0 gives op_a AND op_b, 1 gives OR, 2 gives XOR, and 3 gives op_a AND NOT op_b.
- R4: For class SHL (6) the result is op_a[14:0] followed by a 0 in bit 0.
- R5: For class SRL (7) the result is {0, op_a[15:1]}. For class SRA (8) it is {op_a[15], op_a[15:1]}.
- R6: For class LDB (9) result[15:8] is 0 and result[7:0] equals byte_in.
- R7: For class LINK (10) the result equals ret_addr.
- R8: For class NONE (0, used by stores, branches and immediate prefixes), and for any unused code 11..15, all unit enables are high and the result is 0.
- R9: unit_en_n is active low with at most one bit low. The bits are: 0 adder (ADD, SUB, ADC, SBC), 1 logic, 2 left shift, 3 right shift (SRL, SRA), 4 byte zero-extend, 5 return address.
- R10: carry_flag resets to 0. After a clock edge in an ADD/SUB/ADC/SBC cycle it equals that cycle's carry_out. After any other cycle it is unchanged.
- R11: byte_in has no effect on result except in class LDB. ret_addr has no effect on result except in class LINK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| op_class | input | 4 | Decoded operation class code |
| fn_sel | input | 2 | Logic function code |
| byte_in | input | 8 | Byte-load data |
| ret_addr | input | 16 | Return address for link operations |
| result | output | 16 | Selected result |
| carry_out | output | 1 | Adder carry-out in the current cycle |
| carry_flag | output | 1 | Registered carry from the last arithmetic operation |
| unit_en_n | output | 6 | Active-low one-hot unit enables |

## Verification
result, carry_out and unit_en_n are combinational and are due in the same cycle the operands and class are applied. The bench drives its inputs on the falling edge and samples these outputs two nanoseconds later, before the next rising edge. carry_flag changes only at the rising edge that ends an arithmetic cycle, so the bench checks it one nanosecond after that edge. The vector table is ordered so that each chained add or subtract depends on the flag left behind by the rows before it, including rows of other classes that must leave the flag unchanged.

// File: rtl/ex_alu_pkg.sv
package ex_alu_pkg;

    localparam int CLS_W = 4;

    typedef enum logic [CLS_W-1:0] {
        OP_NONE  = 4'd0,
        OP_ADD   = 4'd1,
        OP_SUB   = 4'd2,
        OP_ADC   = 4'd3,
        OP_SBC   = 4'd4,
        OP_LOGIC = 4'd5,
        OP_SHL   = 4'd6,
        OP_SRL   = 4'd7,
        OP_SRA   = 4'd8,
        OP_LDB   = 4'd9,
        OP_LINK  = 4'd10
    } op_class_e;

    localparam int U_SUM   = 0;
    localparam int U_LOGIC = 1;
    localparam int U_SHL   = 2;
    localparam int U_SHR   = 3;
    localparam int U_ZEXT  = 4;
    localparam int U_LINK  = 5;
    localparam int N_UNITS = 6;

    localparam logic [1:0] FN_AND  = 2'd0;
    localparam logic [1:0] FN_OR   = 2'd1;
    localparam logic [1:0] FN_XOR  = 2'd2;
    localparam logic [1:0] FN_ANDN = 2'd3;

    typedef struct packed {
        logic cflag;
    } ex_state_t;

endpackage

// File: rtl/ex_ctl.sv
module ex_ctl
    import ex_alu_pkg::*;
(
    input  logic [CLS_W-1:0]   op_class,
    input  logic               cflag,
    output logic               sub_mode,
    output logic               cin,
    output logic               sri_arith,
    output logic               arith,
    output logic [N_UNITS-1:0] unit_en
);
    always_comb begin
        sub_mode  = 1'b0;
        cin       = 1'b0;
        sri_arith = 1'b0;
        arith     = 1'b0;
        unit_en   = '0;
        case (op_class)
            OP_ADD: begin
                arith          = 1'b1;
                unit_en[U_SUM] = 1'b1;
            end
            OP_ADC: begin
                arith          = 1'b1;
                cin            = cflag;
                unit_en[U_SUM] = 1'b1;
            end
            OP_SUB: begin
                arith          = 1'b1;
                sub_mode       = 1'b1;
                cin            = 1'b1;
                unit_en[U_SUM] = 1'b1;
            end
            OP_SBC: begin
                arith          = 1'b1;
                sub_mode       = 1'b1;
                cin            = 1'b1 ^ cflag;
                unit_en[U_SUM] = 1'b1;
            end
            OP_LOGIC: unit_en[U_LOGIC] = 1'b1;
            OP_SHL:   unit_en[U_SHL]   = 1'b1;
            OP_SRL:   unit_en[U_SHR]   = 1'b1;
            OP_SRA: begin
                sri_arith      = 1'b1;
                unit_en[U_SHR] = 1'b1;
            end
            OP_LDB:   unit_en[U_ZEXT]  = 1'b1;
            OP_LINK:  unit_en[U_LINK]  = 1'b1;
            default:  unit_en          = '0;
        endcase
    end
endmodule

// File: rtl/ex_addsub.sv
module ex_addsub #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sub_mode,
    input  logic          cin,
    output logic [DW-1:0] sum,
    output logic          cout
);
    logic [DW-1:0] b_eff;
    logic [DW:0]   wide;

    always_comb begin
        b_eff = sub_mode ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, cin};
        sum   = wide[DW-1:0];
        cout  = wide[DW];
    end
endmodule

// File: rtl/ex_logic.sv
module ex_logic
    import ex_alu_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [1:0]    fn,
    output logic [DW-1:0] y
);
    always_comb begin
        case (fn)
            FN_AND:  y = a & b;
            FN_OR:   y = a | b;
            FN_XOR:  y = a ^ b;
            FN_ANDN: y = a & ~b;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/ex_shift.sv
module ex_shift #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] a,
    input  logic          sri_arith,
    output logic [DW-1:0] shl,
    output logic [DW-1:0] shr
);
    logic sri;

    always_comb begin
        sri = sri_arith & a[DW-1];
        shl = {a[DW-2:0], 1'b0};
        shr = {sri, a[DW-1:1]};
    end
endmodule

// File: rtl/ex_resmux.sv
module ex_resmux #(
    parameter int DW = 16,
    parameter int NS = 6
) (
    input  logic [NS-1:0]        en,
    input  logic [NS-1:0][DW-1:0] src,
    output logic [DW-1:0]        y
);
    logic [NS-1:0][DW-1:0] gated;

    for (genvar i = 0; i < NS; i++) begin : g_gate
        assign gated[i] = src[i] & {DW{en[i]}};
    end

    always_comb begin
        y = '0;
        for (int i = 0; i < NS; i++) begin
            y = y | gated[i];
        end
    end
endmodule

// File: rtl/ex_alu16.sv
module ex_alu16
    import ex_alu_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DW-1:0]       op_a,
    input  logic [DW-1:0]       op_b,
    input  logic [CLS_W-1:0]    op_class,
    input  logic [1:0]          fn_sel,
    input  logic [DW/2-1:0]     byte_in,
    input  logic [DW-1:0]       ret_addr,
    output logic [DW-1:0]       result,
    output logic                carry_out,
    output logic                carry_flag,
    output logic [N_UNITS-1:0]  unit_en_n
);
    localparam int BW = DW / 2;

    ex_state_t st_d, st_q;

    logic                       sub_mode, cin, sri_arith, arith;
    logic [N_UNITS-1:0]         unit_en;
    logic [DW-1:0]              sum_y, logic_y, shl_y, shr_y;
    logic                       cout;
    logic [N_UNITS-1:0][DW-1:0] srcs;

    ex_ctl u_ctl (
        .op_class  (op_class),
        .cflag     (st_q.cflag),
        .sub_mode  (sub_mode),
        .cin       (cin),
        .sri_arith (sri_arith),
        .arith     (arith),
        .unit_en   (unit_en)
    );

    ex_addsub #(.DW(DW)) u_addsub (
        .a        (op_a),
        .b        (op_b),
        .sub_mode (sub_mode),
        .cin      (cin),
        .sum      (sum_y),
        .cout     (cout)
    );

    ex_logic #(.DW(DW)) u_logic (
        .a  (op_a),
        .b  (op_b),
        .fn (fn_sel),
        .y  (logic_y)
    );

    ex_shift #(.DW(DW)) u_shift (
        .a         (op_a),
        .sri_arith (sri_arith),
        .shl       (shl_y),
        .shr       (shr_y)
    );

    always_comb begin
        srcs          = '0;
        srcs[U_SUM]   = sum_y;
        srcs[U_LOGIC] = logic_y;
        srcs[U_SHL]   = shl_y;
        srcs[U_SHR]   = shr_y;
        srcs[U_ZEXT]  = {{(DW-BW){1'b0}}, byte_in};
        srcs[U_LINK]  = ret_addr;
    end

    ex_resmux #(.DW(DW), .NS(N_UNITS)) u_mux (
        .en  (unit_en),
        .src (srcs),
        .y   (result)
    );

    always_comb begin
        st_d = st_q;
        if (arith) begin
            st_d.cflag = cout;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign carry_out  = cout;
    assign carry_flag = st_q.cflag;
    assign unit_en_n  = ~unit_en;

endmodule

// File: rtl/ex_alu16_chk.sv
module ex_alu16_chk
    import ex_alu_pkg::*;
#(
    parameter int DW = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [DW-1:0]      op_a,
    input logic [CLS_W-1:0]   op_class,
    input logic [DW/2-1:0]    byte_in,
    input logic [DW-1:0]      ret_addr,
    input logic [DW-1:0]      result,
    input logic               carry_out,
    input logic               carry_flag,
    input logic [N_UNITS-1:0] unit_en_n
);
    logic is_arith;
    assign is_arith = (op_class == OP_ADD) || (op_class == OP_SUB) ||
                      (op_class == OP_ADC) || (op_class == OP_SBC);

    // R9
    en_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~unit_en_n));

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&unit_en_n) |-> (result == '0));

    // R10
    flag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_arith |=> (carry_flag == $past(carry_out)));

    // R10
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_arith |=> $stable(carry_flag));

    // R6
    byte_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == OP_LDB) |-> (result[DW-1:DW/2] == '0 && result[DW/2-1:0] == byte_in));

    // R7
    link_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == OP_LINK) |-> (result == ret_addr));

    // R5
    sra_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == OP_SRA) |-> (result[DW-1] == op_a[DW-1] && result[DW-2:0] == op_a[DW-1:1]));

    // R4
    shl_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == OP_SHL) |-> (result[0] == 1'b0 && result[DW-1:1] == op_a[DW-2:0]));
endmodule

bind ex_alu16 ex_alu16_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_a       (op_a),
    .op_class   (op_class),
    .byte_in    (byte_in),
    .ret_addr   (ret_addr),
    .result     (result),
    .carry_out  (carry_out),
    .carry_flag (carry_flag),
    .unit_en_n  (unit_en_n)
);

// File: tb/ex_alu16_bench.sv
`timescale 1ns/1ps
module ex_alu16_bench;
    import ex_alu_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] op_a = '0, op_b = '0, ret_addr = '0;
    logic [3:0]  op_class = '0;
    logic [1:0]  fn_sel = '0;
    logic [7:0]  byte_in = '0;
    logic [15:0] result;
    logic        carry_out, carry_flag;
    logic [5:0]  unit_en_n;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ex_alu16 u_ex_alu16 (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .op_class(op_class), .fn_sel(fn_sel), .byte_in(byte_in),
        .ret_addr(ret_addr), .result(result), .carry_out(carry_out),
        .carry_flag(carry_flag), .unit_en_n(unit_en_n)
    );

    typedef struct packed {
        logic [3:0]  cls;
        logic [15:0] a;
        logic [15:0] b;
        logic [1:0]  fn;
        logic [7:0]  byt;
        logic [15:0] ret;
        logic [15:0] exp_res;
        logic [5:0]  exp_en;
        logic        exp_co;
        logic        exp_flag;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{4'd1,  16'h1234, 16'h0001, 2'd0, 8'h00, 16'h0000, 16'h1235, 6'b111110, 1'b0, 1'b0}, // R1
        '{4'd1,  16'hFFFF, 16'h0001, 2'd0, 8'h00, 16'h0000, 16'h0000, 6'b111110, 1'b1, 1'b1}, // R1
        '{4'd3,  16'h0001, 16'h0001, 2'd0, 8'h00, 16'h0000, 16'h0003, 6'b111110, 1'b0, 1'b0}, // R1
        '{4'd2,  16'h0005, 16'h0003, 2'd0, 8'h00, 16'h0000, 16'h0002, 6'b111110, 1'b1, 1'b1}, // R2
        '{4'd4,  16'h0005, 16'h0003, 2'd0, 8'h00, 16'h0000, 16'h0001, 6'b111110, 1'b1, 1'b1}, // R2
        '{4'd5,  16'hF0F0, 16'hFF00, 2'd0, 8'h00, 16'h0000, 16'hF000, 6'b111101, 1'b1, 1'b1}, // R3
        '{4'd5,  16'hF0F0, 16'hFF00, 2'd1, 8'h00, 16'h0000, 16'hFFF0, 6'b111101, 1'b1, 1'b1}, // R3
        '{4'd5,  16'hF0F0, 16'hFF00, 2'd2, 8'h00, 16'h0000, 16'h0FF0, 6'b111101, 1'b1, 1'b1}, // R3
        '{4'd5,  16'hF0F0, 16'hFF00, 2'd3, 8'h00, 16'h0000, 16'h00F0, 6'b111101, 1'b1, 1'b1}, // R3
        '{4'd3,  16'h0000, 16'h0000, 2'd0, 8'h00, 16'h0000, 16'h0001, 6'b111110, 1'b0, 1'b0}, // R1
        '{4'd2,  16'h0003, 16'h0005, 2'd0, 8'h00, 16'h0000, 16'hFFFE, 6'b111110, 1'b0, 1'b0}, // R2
        '{4'd6,  16'h8001, 16'h0000, 2'd0, 8'h00, 16'h0000, 16'h0002, 6'b111011, 1'b0, 1'b0}, // R4
        '{4'd7,  16'h8002, 16'h0000, 2'd0, 8'h00, 16'h0000, 16'h4001, 6'b110111, 1'b0, 1'b0}, // R5
        '{4'd8,  16'h8002, 16'h0000, 2'd0, 8'h00, 16'h0000, 16'hC001, 6'b110111, 1'b0, 1'b0}, // R5
        '{4'd8,  16'h4002, 16'h0000, 2'd0, 8'h00, 16'h0000, 16'h2001, 6'b110111, 1'b0, 1'b0}, // R5
        '{4'd9,  16'h1234, 16'h0000, 2'd0, 8'hA5, 16'hFFFF, 16'h00A5, 6'b101111, 1'b0, 1'b0}, // R6 R11
        '{4'd10, 16'h0000, 16'h0000, 2'd0, 8'hFF, 16'hBEEF, 16'hBEEF, 6'b011111, 1'b0, 1'b0}, // R7 R11
        '{4'd0,  16'h1234, 16'h0000, 2'd1, 8'hFF, 16'hBEEF, 16'h0000, 6'b111111, 1'b0, 1'b0}  // R8 R11
    };

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] c, input logic [15:0] a, input logic [15:0] b,
                         input logic [1:0] f, input logic [7:0] by, input logic [15:0] r);
        @(negedge clk);
        op_class = c; op_a = a; op_b = b; fn_sel = f; byte_in = by; ret_addr = r;
        #2;
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R10", "flag in reset", {15'd0, carry_flag}, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        check("R8", "idle result after reset", result, 16'h0000);
        check("R9", "idle enables after reset", {10'd0, unit_en_n}, {10'd0, 6'b111111});

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].cls, VEC[i].a, VEC[i].b, VEC[i].fn, VEC[i].byt, VEC[i].ret);
            check("R1-R8 row", $sformatf("result row %0d", i), result, VEC[i].exp_res);
            check("R9", $sformatf("enables row %0d", i), {10'd0, unit_en_n}, {10'd0, VEC[i].exp_en});
            check("R1 R2", $sformatf("carry_out row %0d", i), {15'd0, carry_out}, {15'd0, VEC[i].exp_co});
            @(posedge clk);
            #1;
            check("R10", $sformatf("flag row %0d", i), {15'd0, carry_flag}, {15'd0, VEC[i].exp_flag});
        end

        // R11: byte_in and ret_addr swept during a logic op leave result untouched
        drive(4'd5, 16'h00FF, 16'h0F0F, 2'd2, 8'h00, 16'h0000);
        check("R11", "xor base", result, 16'h0FF0);
        byte_in = 8'h5A; ret_addr = 16'h1357;
        #1;
        check("R11", "xor after side inputs change", result, 16'h0FF0);

        // R8: unused class code 15 selects nothing
        drive(4'd15, 16'hFFFF, 16'hFFFF, 2'd1, 8'hFF, 16'hFFFF);
        check("R8", "unused class result", result, 16'h0000);
        check("R9", "unused class enables", {10'd0, unit_en_n}, {10'd0, 6'b111111});

        // R10: set flag with a carrying add, hold it across a shift, then clear by reset
        drive(4'd1, 16'h8000, 16'h8000, 2'd0, 8'h00, 16'h0000);
        @(posedge clk); #1;
        check("R10", "flag set by add carry", {15'd0, carry_flag}, 16'd1);
        drive(4'd6, 16'h0001, 16'h0000, 2'd0, 8'h00, 16'h0000);
        @(posedge clk); #1;
        check("R10", "flag held over shift", {15'd0, carry_flag}, 16'd1);
        drive(4'd4, 16'h0005, 16'h0003, 2'd0, 8'h00, 16'h0000);
        check("R2", "sbc with flag 1 borrows", result, 16'h0001);
        rst_n = 1'b0;
        #1;
        check("R10", "flag cleared by reset", {15'd0, carry_flag}, 16'd0);
        check("R2", "sbc with flag 0 after reset", result, 16'h0002);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule